// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small byte-wide processor core. Each cycle it takes an operation code, two 8-bit operands, the current carry flag and the current zero flag. It produces an 8-bit result, a write-enable for that result, and the five status bits: carry (C), zero (Z), negative (N), two's-complement overflow (V) and sign (S). Each operation sets the status bits by its own rule. The complement forces carry high. Logic operations clear overflow. Shifts and rotates derive overflow from N and C. Increment, decrement and negate find overflow by looking at the result alone.

The function itself is purely combinational. It is split into three units: arithmetic, bitwise logic and shift/rotate. A single output register stage captures the selected result and flags, so every result appears on the outputs one clock after its inputs are presented. The incoming zero flag lets the with-carry subtract and compare operations only ever clear Z. A chain of byte operations therefore gives a correct zero test for the whole multi-byte value.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, every output reads zero. Otherwise the outputs show the result of the inputs sampled at the previous rising clock edge.
- R2: Opcodes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 compare-with-carry, 6 AND, 7 OR, 8 XOR, 9 one's complement, 10 negate, 11 increment, 12 decrement, 13 shift left, 14 logical shift right, 15 rotate left, 16 rotate right, 17 arithmetic shift right. For every valid opcode except 3 and 5, Z is 1 exactly when the 8-bit result is zero.
- R3: N equals result bit 7, and S equals N XOR V, for every valid opcode.
- R4: Add gives a+b and add-with-carry gives a+b+c_i, both modulo 256. C is the carry out of bit 7. V is 1 when a[7]==b[7] and the result bit 7 differs from a[7].
- R5: Subtract and compare give a-b, and the with-carry forms give a-b-c_i, modulo 256. C is 1 when the true difference is negative (an unsigned borrow). V is 1 when a[7]!=b[7] and the result bit 7 differs from a[7].
- R6: For subtract-with-carry and compare-with-carry, Z is 1 only when the result is zero and z_i is 1.
- R7: The result write-enable is low for compare, compare-with-carry and unused opcodes, and high for all other opcodes.
- R8: AND, OR and XOR clear V and pass c_i to C.
- R9: One's complement returns ~a, sets C to 1 and clears V.
- R10: Negate returns 0-a. C is 1 when a is nonzero. V is 1 only when the result is 0x80.
- R11: Increment returns a+1 and decrement returns a-1. Both pass c_i to C. V is 1 only for an increment result of 0x80 or a decrement result of 0x7F.
- R12: Every shift and rotate puts the bit shifted out into C and sets V to N XOR C. Shift left and logical shift right fill the vacated end with 0. The rotates fill it with c_i.
- R13: Arithmetic shift right keeps bit 7 and copies it into bit 6, so 0x84 gives 0xC2. Logical shift right, and rotate right with c_i=0, give 0x42 for the same input.
- R14: Opcodes 18 to 31 give result 0 with no write. C takes c_i, Z takes z_i, and N, V and S are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code (see R2) |
| a_i | input | 8 | First operand; sole operand of unary operations |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Incoming carry flag |
| z_i | input | 1 | Incoming zero flag, used by the chained subtract/compare |
| res_o | output | 8 | Registered result |
| wr_o | output | 1 | Registered result write-enable |
| flag_c_o | output | 1 | Carry / borrow |
| flag_z_o | output | 1 | Zero |
| flag_n_o | output | 1 | Negative |
| flag_v_o | output | 1 | Two's-complement overflow |
| flag_s_o | output | 1 | Sign, N XOR V |

## Verification
Every result and every flag is due exactly one rising edge after its operands are presented, because only one register stage lies between input and output. The bench drives a new operation on each falling edge. On the next falling edge, half a cycle after the capturing edge, it compares all outputs against a behavioural model that uses signed integer range tests for overflow. Directed cases hit the overflow boundaries 0x7F/0x80, borrow from zero, the zero-chain case, and the 0x84 shift examples. A long run of random operations then covers every opcode, including the unused codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_CMPC = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_INV  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_SHL  = 5'd13,
        OP_SHR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_SAR  = 5'd17
    } alu_op_e;

    // carry and overflow produced by one operation unit
    typedef struct packed {
        logic c;
        logic v;
    } cv_t;

    function automatic logic is_chained(alu_op_e op);
        return (op == OP_SBC) || (op == OP_CMPC);
    endfunction

    function automatic logic is_compare(alu_op_e op);
        return (op == OP_CMP) || (op == OP_CMPC);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output cv_t            cv
);
    localparam int         MSB  = W - 1;
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] SMAX = ~SMIN;

    logic [W:0] wide_a, wide_b, wide_c, acc;

    assign wide_a = {1'b0, a};
    assign wide_b = {1'b0, b};
    assign wide_c = {{W{1'b0}}, cin};

    always_comb begin
        acc  = '0;
        res  = '0;
        cv.c = cin;
        cv.v = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                acc  = wide_a + wide_b + ((op == OP_ADC) ? wide_c : '0);
                res  = acc[MSB:0];
                cv.c = acc[W];
                cv.v = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_SUB, OP_SBC, OP_CMP, OP_CMPC: begin
                acc  = wide_a - wide_b - (is_chained(op) ? wide_c : '0);
                res  = acc[MSB:0];
                cv.c = acc[W];
                cv.v = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_NEG: begin
                acc  = '0 - wide_a;
                res  = acc[MSB:0];
                cv.c = |a;
                cv.v = (res == SMIN);
            end
            OP_INC: begin
                res  = a + 1'b1;
                cv.v = (res == SMIN);
            end
            OP_DEC: begin
                res  = a - 1'b1;
                cv.v = (res == SMAX);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output cv_t            cv
);
    always_comb begin
        res  = '0;
        cv.c = cin;
        cv.v = 1'b0;
        case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_INV: begin
                res  = ~a;
                cv.c = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output logic [W-1:0]   res,
    output cv_t            cv
);
    localparam int MSB = W - 1;

    logic fill;

    always_comb begin
        res  = '0;
        fill = 1'b0;
        cv.c = cin;
        case (op)
            OP_SHL, OP_ROL: begin
                fill = (op == OP_ROL) ? cin : 1'b0;
                res  = {a[MSB-1:0], fill};
                cv.c = a[MSB];
            end
            OP_SHR, OP_ROR, OP_SAR: begin
                case (op)
                    OP_ROR:  fill = cin;
                    OP_SAR:  fill = a[MSB];
                    default: fill = 1'b0;
                endcase
                res  = {fill, a[MSB:1]};
                cv.c = a[0];
            end
            default: ;
        endcase
        cv.v = res[MSB] ^ cv.c;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           c_i,
    input  logic           z_i,
    output logic [W-1:0]   res_o,
    output logic           wr_o,
    output logic           flag_c_o,
    output logic           flag_z_o,
    output logic           flag_n_o,
    output logic           flag_v_o,
    output logic           flag_s_o
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         wr;
        logic         c;
        logic         z;
        logic         n;
        logic         v;
        logic         s;
    } state_t;

    state_t st_d, st_q;
    alu_op_e op;
    logic [W-1:0] ar_res, lg_res, sh_res, pick_res;
    cv_t ar_cv, lg_cv, sh_cv, pick_cv;
    logic known;

    assign op = alu_op_e'(op_i);

    alu8_arith #(.W(W)) u_arith (
        .op(op), .a(a_i), .b(b_i), .cin(c_i), .res(ar_res), .cv(ar_cv)
    );
    alu8_logic #(.W(W)) u_logic (
        .op(op), .a(a_i), .b(b_i), .cin(c_i), .res(lg_res), .cv(lg_cv)
    );
    alu8_shift #(.W(W)) u_shift (
        .op(op), .a(a_i), .cin(c_i), .res(sh_res), .cv(sh_cv)
    );

    // unit select
    always_comb begin
        known    = 1'b1;
        pick_res = ar_res;
        pick_cv  = ar_cv;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC,
            OP_NEG, OP_INC, OP_DEC: ;
            OP_AND, OP_OR, OP_XOR, OP_INV: begin
                pick_res = lg_res;
                pick_cv  = lg_cv;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_SAR: begin
                pick_res = sh_res;
                pick_cv  = sh_cv;
            end
            default: begin
                known     = 1'b0;
                pick_res  = '0;
                pick_cv.c = c_i;
                pick_cv.v = 1'b0;
            end
        endcase
    end

    // next state: common flag rules
    always_comb begin
        st_d.res = pick_res;
        st_d.c   = pick_cv.c;
        st_d.v   = pick_cv.v;
        st_d.n   = known & pick_res[MSB];
        st_d.s   = st_d.n ^ st_d.v;
        st_d.wr  = known & ~is_compare(op);
        if (!known)
            st_d.z = z_i;
        else if (is_chained(op))
            st_d.z = (pick_res == '0) & z_i;
        else
            st_d.z = (pick_res == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o    = st_q.res;
    assign wr_o     = st_q.wr;
    assign flag_c_o = st_q.c;
    assign flag_z_o = st_q.z;
    assign flag_n_o = st_q.n;
    assign flag_v_o = st_q.v;
    assign flag_s_o = st_q.s;

    assert_zero_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z_o |-> (res_o == '0));

    assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(op_i) == OP_CMP) || ($past(op_i) == OP_CMPC))) |-> !wr_o);

    assert_com_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_INV)
            |-> (flag_c_o && !flag_v_o && res_o == ~$past(a_i)));

    assert_neg_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_NEG) |-> (flag_c_o == ($past(a_i) != '0)));

    assert_incdec_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(op_i) == OP_INC) || ($past(op_i) == OP_DEC)))
            |-> (flag_c_o == $past(c_i)));

    assert_shift_s_eq_c_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) >= OP_SHL && $past(op_i) <= OP_SAR)
            |-> (flag_s_o == flag_c_o));

    assert_sar_sign_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_SAR)
            |-> (res_o[MSB] == $past(a_i[MSB]) && res_o[MSB-1] == $past(a_i[MSB])));

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0, b_i = '0;
    logic c_i = 1'b0, z_i = 1'b0;
    logic [7:0] res_o;
    logic wr_o, flag_c_o, flag_z_o, flag_n_o, flag_v_o, flag_s_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .c_i(c_i), .z_i(z_i), .res_o(res_o), .wr_o(wr_o),
        .flag_c_o(flag_c_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o),
        .flag_v_o(flag_v_o), .flag_s_o(flag_s_o)
    );

    function automatic string tag_of(int op);
        if (op <= 1)  return "R4";
        if (op <= 5)  return "R5";
        if (op <= 8)  return "R8";
        if (op == 9)  return "R9";
        if (op == 10) return "R10";
        if (op <= 12) return "R11";
        if (op <= 17) return "R12";
        return "R14";
    endfunction

    function automatic int sgn(int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // packed as {res[7:0], wr, c, z, n, v, s}
    function automatic logic [13:0] model(int op, int a, int b, int c, int z);
        int r, t;
        int wr, cf, zf, nf, vf;
        wr = 1; cf = c; vf = 0; r = 0;
        case (op)
            0, 1: begin
                t  = a + b + ((op == 1) ? c : 0);
                r  = t % 256; cf = (t > 255);
                t  = sgn(a) + sgn(b) + ((op == 1) ? c : 0);
                vf = (t > 127 || t < -128);
            end
            2, 3, 4, 5: begin
                t  = (op == 3 || op == 5) ? c : 0;
                r  = (a - b - t + 512) % 256; cf = (a < b + t);
                t  = sgn(a) - sgn(b) - t;
                vf = (t > 127 || t < -128);
                if (op >= 4) wr = 0;
            end
            6: r = a & b;
            7: r = a | b;
            8: r = a ^ b;
            9: begin r = 255 - a; cf = 1; end
            10: begin r = (256 - a) % 256; cf = (a != 0); vf = (r == 128); end
            11: begin r = (a + 1) % 256; vf = (r == 128); end
            12: begin r = (a + 255) % 256; vf = (r == 127); end
            13: begin r = (a * 2) % 256; cf = a / 128; end
            14: begin r = a / 2; cf = a % 2; end
            15: begin r = (a * 2) % 256 + c; cf = a / 128; end
            16: begin r = a / 2 + 128 * c; cf = a % 2; end
            17: begin r = a / 2 + (a & 128); cf = a % 2; end
            default: begin r = 0; wr = 0; end
        endcase
        nf = (op <= 17) ? r / 128 : 0;
        if (op >= 13 && op <= 17) vf = nf ^ cf;
        if (op > 17) zf = z;
        else if (op == 3 || op == 5) zf = (r == 0) && z;
        else zf = (r == 0);
        return {r[7:0], wr[0], cf[0], zf[0], nf[0], vf[0], nf[0] ^ vf[0]};
    endfunction

    task automatic check(string tag, logic [13:0] exp);
        logic [13:0] act;
        act = {res_o, wr_o, flag_c_o, flag_z_o, flag_n_o, flag_v_o, flag_s_o};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got res=%02h wr,c,z,n,v,s=%06b expected res=%02h wr,c,z,n,v,s=%06b",
                     tag, act[13:6], act[5:0], exp[13:6], exp[5:0]);
        end
    endtask

    // drive at a falling edge, compare one full cycle later (R1 latency)
    task automatic apply(string tag, int op, int a, int b, int c, int z);
        @(negedge clk);
        op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0]; c_i = c[0]; z_i = z[0];
        @(negedge clk);
        check(tag, model(op, a, b, c, z));
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        op_i = 5'd6; a_i = 8'hFF; b_i = 8'hFF; c_i = 1'b1; z_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", 14'd0);
        rst_n = 1'b1;

        apply("R4 add carry", 0, 8'hF0, 8'h20, 0, 0);
        apply("R4 add overflow", 0, 8'h7F, 8'h01, 0, 0);
        apply("R4 adc zero", 1, 8'hFF, 8'h00, 1, 0);
        apply("R5 sub borrow", 2, 8'h00, 8'h01, 0, 0);
        apply("R5 sub overflow", 2, 8'h80, 8'h01, 0, 0);
        apply("R6 sbc chain keep", 3, 8'h05, 8'h04, 1, 1);
        apply("R6 sbc chain clear", 3, 8'h05, 8'h04, 1, 0);
        apply("R7 cmp no write", 4, 8'h10, 8'h10, 0, 0);
        apply("R7 cmpc no write", 5, 8'h10, 8'h0F, 1, 1);
        apply("R8 and keeps carry", 6, 8'hF0, 8'h0F, 1, 0);
        apply("R8 xor sign", 8, 8'h80, 8'h00, 0, 0);
        apply("R9 com", 9, 8'hFF, 8'h00, 0, 0);
        apply("R10 neg zero", 10, 8'h00, 8'h00, 1, 0);
        apply("R10 neg overflow", 10, 8'h80, 8'h00, 0, 0);
        apply("R11 inc overflow", 11, 8'h7F, 8'h00, 1, 0);
        apply("R11 dec overflow", 12, 8'h80, 8'h00, 0, 0);
        apply("R12 rol in carry", 15, 8'h40, 8'h00, 1, 0);
        apply("R12 shl sign", 13, 8'h40, 8'h00, 0, 0);
        apply("R13 asr 0x84", 17, 8'h84, 8'h00, 0, 0);
        apply("R13 lsr 0x84", 14, 8'h84, 8'h00, 1, 0);
        apply("R13 ror 0x84", 16, 8'h84, 8'h00, 0, 0);
        apply("R14 unused", 25, 8'h12, 8'h34, 1, 1);
        apply("R3 sign flag", 2, 8'h95, 8'h18, 0, 0);
        apply("R2 zero flag", 7, 8'h00, 8'h00, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            int op, a, b, c, z;
            op = $urandom_range(0, 31);
            a  = $urandom_range(0, 255);
            b  = $urandom_range(0, 255);
            c  = $urandom_range(0, 1);
            z  = $urandom_range(0, 1);
            apply(tag_of(op), op, a, b, c, z);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule